// File: doc/BRIEF.md
# SPI Flash Command Controller

This block is an SPI master that runs one serial-flash command at a time under the control of a byte-wide register bus. Host software stages a command by writing three things: an opcode byte, a packed send/receive byte count, and any payload bytes. The payload goes through a single data port into an eight-slot ring buffer. A start bit in the control register then runs the whole frame with no further host involvement. The controller pulls chip select low and shifts out the opcode, the payload bytes, and as many filler bytes as the receive count asks for.

Each byte that arrives after the opcode is written back into the ring buffer. It goes to the slot with the same index as the byte's position after the opcode. Received bytes therefore replace the payload that was just sent, and the response data begins at the slot numbered by the send count. The buffer is never cleared between commands, so a slot keeps its old contents until a frame or the host overwrites it. The host polls the busy bit until the frame ends, rewinds the buffer pointer and reads the results back through the same data port.

The register bus is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address. A read strobe on the data port advances the pointer at that edge.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: The opcode register is at address 0x0. The count register is at address 0x1: bits 3:0 hold the send count and bits 7:4 hold the receive count. Both registers read back what was written.
- R2: Address 0xC is the data port. A write stores the byte in the slot the pointer selects. A read returns that slot. Each access advances the pointer by one. Address 0xD bits 2:0 read the pointer, which wraps from 7 to 0.
- R3: A write of any value to address 0xD sets the pointer to 0. This holds at any time, including while a frame is running.
- R4: A frame uses mode 0: SCLK idles low, data is sampled on the rising edge and MSB goes first. It sends the opcode, then buffer slots 0 to send-1, then receive-count bytes of 0xFF, with exactly 8*(1+send+receive) SCLK pulses.
- R5: The byte received during the k-th byte after the opcode is stored in slot k, for the send bytes as well as the receive bytes. Response data therefore starts at slot index send.
- R6: Slots that a frame does not reach keep their previous contents. Buffer contents are zero only after reset.
- R7: A command with a send count of 0 captures every requested receive byte, including the last. Chip select stays low through the final bit.
- R8: Writing 1 to bit 0 of the control register at address 0x2 starts a frame. Control bit 0 reads 1 from the next cycle until chip select rises. Chip select stays low for (16*(1+send+receive)+1)*CLK_DIV clock cycles.
- R9: If send+receive exceeds 8, a start request is ignored and a sticky error flag (control bit 1) is set. Writing 1 to control bit 1 while idle clears the flag.
- R10: While a frame runs, writes to addresses 0x0, 0x1, 0x2 and 0xC are ignored, and data-port reads do not move the pointer.
- R11: After reset, chip select is high, SCLK is low, the pointer is 0, the control register reads 0 and every buffer slot reads 0.
- R12: SCLK is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (advances the pointer on the data port) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
If the byte index inside the shifter went wrong, a received byte would land in the wrong slot or a payload byte would be sent out of order. The host would see this on the first data-port read after the frame. It would also show on MOSI within the byte where the index slips. A wrong shift-phase or half-period counter moves the chip-select release off its computed cycle, and the per-cycle comparison of chip select catches that on the cycle it happens. Errors in the pointer or in the busy-time write gating show on the very next pointer read, or as a changed opcode when it is read back after the frame.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Register addresses; the host software decodes these, so they are fixed.
  localparam logic [3:0] ADR_OPCODE = 4'h0;
  localparam logic [3:0] ADR_COUNT  = 4'h1;
  localparam logic [3:0] ADR_CTRL   = 4'h2;
  localparam logic [3:0] ADR_DATA   = 4'hC;
  localparam logic [3:0] ADR_PTR    = 4'hD;

  // Control register bit positions.
  localparam int unsigned CTRL_GO  = 0;
  localparam int unsigned CTRL_ERR = 1;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_TAIL
  } eng_state_e;

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  output logic              start,
  output logic [DATA_W-1:0] opcode,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic              err,
  output logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  eng_rd_idx,
  output logic [DATA_W-1:0] eng_tx_byte,
  input  logic              eng_we,
  input  logic [PTR_W-1:0]  eng_wr_idx,
  input  logic [DATA_W-1:0] eng_wdata
);
  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(DEPTH);

  logic [DATA_W-1:0] ring_q [DEPTH];
  logic [DATA_W-1:0] opcode_q;
  logic [CNT_W-1:0]  tx_q, rx_q;
  logic              err_q;
  logic [PTR_W-1:0]  ptr_q;

  logic [CNT_W:0] span;
  logic           fits;
  logic           wr_ok;
  logic           go_req;
  logic           host_store;
  logic           host_step;

  assign span       = {1'b0, tx_q} + {1'b0, rx_q};
  assign fits       = (span <= LIMIT);
  assign wr_ok      = wr_en && !busy;
  assign go_req     = wr_ok && (addr == ADR_CTRL) && wdata[CTRL_GO];
  assign start      = go_req && fits;
  assign host_store = wr_ok && (addr == ADR_DATA);
  assign host_step  = !busy && (wr_en || rd_en) && (addr == ADR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr_ok && (addr == ADR_OPCODE)) opcode_q <= wdata;
      if (wr_ok && (addr == ADR_COUNT)) begin
        tx_q <= wdata[CNT_W-1:0];
        rx_q <= wdata[2*CNT_W-1:CNT_W];
      end
      if (go_req && !fits) begin
        err_q <= 1'b1;
      end else if (wr_ok && (addr == ADR_CTRL) && wdata[CTRL_ERR]) begin
        err_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr_en && (addr == ADR_PTR)) begin
      ptr_q <= '0;
    end else if (host_step) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  // Ring storage: one writer per slot per cycle (host only while idle,
  // shifter only while busy).
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ring_q[s] <= '0;
      end else if (eng_we && (eng_wr_idx == PTR_W'(s))) begin
        ring_q[s] <= eng_wdata;
      end else if (host_store && (ptr_q == PTR_W'(s))) begin
        ring_q[s] <= wdata;
      end
    end
  end

  assign eng_tx_byte = ring_q[eng_rd_idx];

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_OPCODE: rdata = opcode_q;
      ADR_COUNT:  rdata = DATA_W'({rx_q, tx_q});
      ADR_CTRL:   rdata = DATA_W'({err_q, busy});
      ADR_DATA:   rdata = ring_q[ptr_q];
      ADR_PTR:    rdata = DATA_W'(ptr_q);
      default:    rdata = '0;
    endcase
  end

  assign opcode = opcode_q;
  assign tx_cnt = tx_q;
  assign rx_cnt = rx_q;
  assign err    = err_q;
  assign ptr    = ptr_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned CLK_DIV = 2,
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] opcode,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [PTR_W-1:0]  rd_idx,
  output logic [PTR_W-1:0]  wr_idx,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  localparam int unsigned IDX_W = CNT_W + 1;
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(DATA_W - 1);

  eng_state_e        state_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  byte_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  sends_q;
  logic              sclk_q;
  logic              run;
  logic              tick;
  logic              byte_end;
  logic [IDX_W-1:0]  prev_idx;

  assign run = (state_q != ENG_IDLE);

  spi_cmd_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  // Falling edge that completes a byte.
  assign byte_end = (state_q == ENG_SHIFT) && tick && sclk_q && (bit_q == '0);
  assign prev_idx = byte_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      last_q  <= '0;
      sends_q <= '0;
      sclk_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          sclk_q <= 1'b0;
          if (start) begin
            state_q <= ENG_SHIFT;
            tx_sh_q <= opcode;
            bit_q   <= BIT_TOP;
            byte_q  <= '0;
            last_q  <= {1'b0, tx_cnt} + {1'b0, rx_cnt};
            sends_q <= {1'b0, tx_cnt};
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q  <= 1'b1;
              rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == '0) begin
                if (byte_q == last_q) begin
                  state_q <= ENG_TAIL;
                end else begin
                  byte_q  <= byte_q + 1'b1;
                  bit_q   <= BIT_TOP;
                  tx_sh_q <= (byte_q < sends_q) ? tx_byte : '1;
                end
              end else begin
                bit_q   <= bit_q - 1'b1;
                tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
              end
            end
          end
        end
        ENG_TAIL: begin
          if (tick) state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign rd_idx = byte_q[PTR_W-1:0];
  assign wr_idx = prev_idx[PTR_W-1:0];
  assign we     = byte_end && (byte_q != '0);
  assign wdata  = rx_sh_q;
  assign busy   = run;
  assign cs_n   = !run;
  assign sclk   = sclk_q;
  assign mosi   = run ? tx_sh_q[DATA_W-1] : 1'b0;
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic              start_pulse;
  logic              eng_busy;
  logic [DATA_W-1:0] opcode_q;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              err_q;
  logic [PTR_W-1:0]  host_ptr;
  logic [PTR_W-1:0]  eng_rd_idx, eng_wr_idx;
  logic [DATA_W-1:0] eng_tx_byte, eng_wdata;
  logic              eng_we;

  spi_cmd_regs #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .busy       (eng_busy),
    .start      (start_pulse),
    .opcode     (opcode_q),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .err        (err_q),
    .ptr        (host_ptr),
    .eng_rd_idx (eng_rd_idx),
    .eng_tx_byte(eng_tx_byte),
    .eng_we     (eng_we),
    .eng_wr_idx (eng_wr_idx),
    .eng_wdata  (eng_wdata)
  );

  spi_cmd_engine #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .CLK_DIV(CLK_DIV)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_pulse),
    .opcode (opcode_q),
    .tx_cnt (tx_cnt),
    .rx_cnt (rx_cnt),
    .tx_byte(eng_tx_byte),
    .rd_idx (eng_rd_idx),
    .wr_idx (eng_wr_idx),
    .we     (eng_we),
    .wdata  (eng_wdata),
    .busy   (eng_busy),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .cs_n   (spi_cs_n),
    .miso   (spi_miso)
  );
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [3:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic [PTR_W-1:0]  host_ptr,
  input logic [DATA_W-1:0] opcode_q,
  input logic              err_q,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt
);
  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(DEPTH);

  logic [CNT_W:0] span;
  assign span = {1'b0, tx_cnt} + {1'b0, rx_cnt};

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R12

  AST_CS_FALL_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(reg_wr_en && (reg_addr == ADR_CTRL) && reg_wdata[CTRL_GO])); // R8

  AST_OVERSIZE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (reg_addr == ADR_CTRL) && reg_wdata[CTRL_GO] && spi_cs_n && (span > LIMIT))
    |=> (spi_cs_n && err_q)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(reg_wr_en && (reg_addr == ADR_CTRL) && reg_wdata[CTRL_ERR])) |=> err_q); // R9

  AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (reg_addr == ADR_PTR)) |=> (host_ptr == '0)); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !reg_wr_en && (reg_addr == ADR_DATA) && spi_cs_n)
    |=> (host_ptr == PTR_W'($past(host_ptr) + 1'b1))); // R2

  AST_OPCODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && reg_wr_en && (reg_addr == ADR_OPCODE)) |=> $stable(opcode_q)); // R10
endmodule

bind spi_cmd_ctrl spi_cmd_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr_en(reg_wr_en),
  .reg_rd_en(reg_rd_en),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .host_ptr (host_ptr),
  .opcode_q (opcode_q),
  .err_q    (err_q),
  .tx_cnt   (tx_cnt),
  .rx_cnt   (rx_cnt)
);

// File: tb/test_spi_cmd_ctrl.sv
module test_spi_cmd_ctrl;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en = 1'b0;
  logic       reg_rd_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_cs_n, spi_mosi;
  logic       miso_q = 1'b0;

  always #10 clk = ~clk;

  spi_cmd_ctrl #(.CLK_DIV(DIV)) i_spi_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(miso_q)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model state: chip-select window and flash-side behaviour.
  int         cs_left = 0;
  bit         pend = 0;
  int         pend_n = 0;
  logic       sclk_prev = 1'b0;
  int         sbit = 0;
  int         rises = 0;
  logic [7:0] slave_b [16];
  logic [7:0] mosi_b  [16];
  int         cyc = 0;

  always @(posedge clk) begin
    #2;
    if (pend) begin
      cs_left = pend_n;
      pend = 0;
    end
    chk("R8 chip select window", spi_cs_n, (cs_left == 0) ? 1 : 0);
    chk("R12 idle clock", spi_sclk & spi_cs_n, 0);
    if (cs_left > 0) cs_left--;
    if (spi_cs_n) begin
      sbit = 0;
    end else begin
      if (spi_sclk && !sclk_prev) begin
        mosi_b[rises/8] = {mosi_b[rises/8][6:0], spi_mosi};
        rises++;
      end
      if (!spi_sclk && sclk_prev) sbit++;
    end
    sclk_prev = spi_sclk;
    miso_q = slave_b[sbit/8][7 - (sbit % 8)];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #5 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic go(input logic [7:0] opc, input int tx, input int rx);
    wr(4'h0, opc);
    wr(4'h1, 8'((rx << 4) | tx));
    rises = 0;
    for (int i = 0; i < 16; i++) mosi_b[i] = 8'h00;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 4'h2; reg_wdata = 8'h01;
    if (tx + rx <= 8) begin
      pend = 1;
      pend_n = (16 * (1 + tx + rx) + 1) * DIV;
    end
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!spi_cs_n || cs_left > 0 || pend);
  endtask

  logic [7:0] v;

  initial begin
    for (int i = 0; i < 16; i++) slave_b[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rd(4'h2, v); chk("R11 control", v, 8'h00);
    rd(4'hD, v); chk("R11 pointer", v, 8'h00);
    chk("R11 cs_n", spi_cs_n, 1);
    chk("R11 sclk", spi_sclk, 0);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v); chk("R11 slot", v, 8'h00);
    end
    rd(4'hD, v); chk("R2 wrap after eight reads", v, 8'h00);

    // Register readback
    wr(4'h0, 8'h9F); wr(4'h1, 8'h30);
    rd(4'h0, v); chk("R1 opcode", v, 8'h9F);
    rd(4'h1, v); chk("R1 count", v, 8'h30);

    // Zero-send command, three receive bytes
    slave_b[0] = 8'hA5; slave_b[1] = 8'h11; slave_b[2] = 8'h22; slave_b[3] = 8'h33;
    go(8'h9F, 0, 3);
    wait_idle();
    chk("R7 pulse count", rises, 32);
    chk("R4 opcode on MOSI", mosi_b[0], 8'h9F);
    for (int i = 1; i < 4; i++) chk("R4 filler on MOSI", mosi_b[i], 8'hFF);
    wr(4'hD, 8'h00);
    rd(4'hC, v); chk("R7 first byte", v, 8'h11);
    rd(4'hC, v); chk("R7 second byte", v, 8'h22);
    rd(4'hC, v); chk("R7 last byte", v, 8'h33);
    rd(4'hD, v); chk("R2 pointer after reads", v, 8'h03);
    rd(4'hC, v); chk("R6 untouched slot", v, 8'h00);

    // Fill all slots through the port
    wr(4'hD, 8'h00);
    for (int i = 0; i < 8; i++) wr(4'hC, 8'hE0 + 8'(i));
    rd(4'hD, v); chk("R2 wrap after eight writes", v, 8'h00);
    rd(4'hC, v); chk("R2 write readback", v, 8'hE0);

    // Send three, receive four
    slave_b[0] = 8'h5A;
    for (int i = 1; i < 8; i++) slave_b[i] = 8'h40 + 8'(i);
    go(8'h03, 3, 4);
    wait_idle();
    chk("R4 pulse count", rises, 64);
    chk("R4 opcode", mosi_b[0], 8'h03);
    for (int i = 1; i < 4; i++) chk("R4 payload order", mosi_b[i], 8'hDF + 8'(i));
    for (int i = 4; i < 8; i++) chk("R4 filler", mosi_b[i], 8'hFF);
    wr(4'hD, 8'h00);
    for (int i = 0; i < 3; i++) begin
      rd(4'hC, v); chk("R5 send-phase capture", v, 8'h41 + 8'(i));
    end
    rd(4'hC, v); chk("R5 response starts at send index", v, 8'h44);
    for (int i = 4; i < 7; i++) begin
      rd(4'hC, v); chk("R5 response", v, 8'h41 + 8'(i));
    end
    rd(4'hC, v); chk("R6 stale slot kept", v, 8'hE7);

    // Oversize request
    wr(4'h1, 8'h45);
    wr(4'h2, 8'h01);
    repeat (4) @(negedge clk);
    rd(4'h2, v); chk("R9 error set, not busy", v, 8'h02);
    wr(4'h2, 8'h02);
    rd(4'h2, v); chk("R9 error cleared", v, 8'h00);

    // Busy-time writes ignored, pointer rewind still allowed
    wr(4'hD, 8'h00);
    for (int i = 0; i < 5; i++) rd(4'hC, v);
    for (int i = 1; i < 9; i++) slave_b[i] = 8'h80 + 8'(i);
    go(8'hAB, 0, 8);
    wr(4'h0, 8'h77);
    wr(4'hC, 8'h99);
    rd(4'hC, v);
    rd(4'hD, v); chk("R10 pointer frozen while busy", v, 8'h05);
    rd(4'h2, v); chk("R8 busy bit", v, 8'h01);
    wr(4'hD, 8'h00);
    rd(4'hD, v); chk("R3 rewind while busy", v, 8'h00);
    wait_idle();
    rd(4'h0, v); chk("R10 opcode unchanged", v, 8'hAB);
    rd(4'h2, v); chk("R8 busy cleared", v, 8'h00);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v); chk("R10 slot not overwritten by host", v, 8'h81 + 8'(i));
    end

    // Opcode-only command
    go(8'h06, 0, 0);
    wait_idle();
    chk("R4 opcode-only pulses", rises, 8);
    chk("R4 opcode-only byte", mosi_b[0], 8'h06);
    wr(4'hD, 8'h00);
    rd(4'hC, v); chk("R6 slot unchanged by opcode-only", v, 8'h81);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule